// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Open-Drain Emulation

This block is a general-purpose I/O port of up to 32 pins in which every pin is shared with an alternate on-chip function. Software uses a simple word-addressed register bus to program four control registers: output value, direction, open-drain enable and alternate-function select. It also reads back the pad inputs after they pass through a two-flop synchronizer.

For each pin the block drives a pad value and a pad output enable. Three cases decide them. When the alternate-select bit is set, both signals come from the alternate function. When it is clear and open-drain is enabled, the pin drives low for an output bit of 0 and is released (enable off) for an output bit of 1. Otherwise the pin is push-pull, with the output enable set by the direction bit.

Top module: `gpio_od_port`

## Requirements
- R1: After reset every control register reads 0, `pad_oe` is all zeros and `pad_o` is all zeros for every pin not given to its alternate function.
- R2: A bus write (`bus_we`=1) to word index 0 (output), 1 (direction), 2 (open-drain enable) or 3 (alternate select) stores `bus_wdata`. The new value reads back on `bus_rdata` when `bus_addr` selects that index. Reads are combinational.
- R3: For a pin whose alternate-select bit is 0 and whose open-drain bit is 0, `pad_o` equals the output bit and `pad_oe` equals the direction bit.
- R4: For a pin whose alternate-select bit is 0 and whose open-drain bit is 1, `pad_o` is 0 and `pad_oe` is the inverse of the output bit. The direction bit has no effect on such a pin.
- R5: For a pin whose alternate-select bit is 1, `pad_o` equals `alt_o` and `pad_oe` equals `alt_oe`. The output, direction and open-drain bits of that pin have no effect on the pad.
- R6: Word index 4 reads the pad inputs through a two-flop synchronizer. A change on `pad_i` is visible after the second rising clock edge and not after the first.
- R7: Writes to index 4 or to indices 5..7 change no register. Reads of indices 5..7 return 0.
- R8: The pad outputs reflect a register write from the first rising clock edge that samples the write.
- R9: The input register follows `pad_i` whatever the pin's select, direction or open-drain settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alt_o | input | 32 | Alternate function output values |
| alt_oe | input | 32 | Alternate function output enables |
| pad_i | input | 32 | Pad input values |
| pad_o | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The assertions assume that `pad_i` is a free-running asynchronous input and that bus writes are single-cycle strobes that occur only after the internal reset has been released. The synchronizer check also assumes that at least two clock cycles have passed since that release, and the checker counts those cycles itself. The bench drives every input at the falling clock edge and waits several cycles after reset before the first access. It samples the pads and the read data just before the next rising edge, so each input is held stable across every edge the assertions reason about.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_OUT = 0;
  localparam int REG_DIR = 1;
  localparam int REG_ODE = 2;
  localparam int REG_ALT = 3;
  localparam int REG_IN  = 4;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end
  assign srst_n = s2_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end
  assign q = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  in_sync,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  ode_q,
  output logic [W-1:0]  alt_q
);
  logic en_out, en_dir, en_ode, en_alt;
  logic [W-1:0] out_d, dir_d, ode_d, alt_d;

  always_comb begin
    en_out = we && (addr == AW'(REG_OUT));
    en_dir = we && (addr == AW'(REG_DIR));
    en_ode = we && (addr == AW'(REG_ODE));
    en_alt = we && (addr == AW'(REG_ALT));
    out_d  = en_out ? wdata : out_q;
    dir_d  = en_dir ? wdata : dir_q;
    ode_d  = en_ode ? wdata : ode_q;
    alt_d  = en_alt ? wdata : alt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      ode_q <= '0;
      alt_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
      ode_q <= ode_d;
      alt_q <= alt_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(REG_OUT)) rdata = out_q;
    if (addr == AW'(REG_DIR)) rdata = dir_q;
    if (addr == AW'(REG_ODE)) rdata = ode_q;
    if (addr == AW'(REG_ALT)) rdata = alt_q;
    if (addr == AW'(REG_IN))  rdata = in_sync;
  end
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int W = 32
) (
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] ode_q,
  input  logic [W-1:0] alt_q,
  input  logic [W-1:0] alt_o,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (alt_q[i]) begin
        pad_o[i]  = alt_o[i];
        pad_oe[i] = alt_oe[i];
      end else if (ode_q[i]) begin
        pad_o[i]  = 1'b0;
        pad_oe[i] = ~out_q[i];
      end else begin
        pad_o[i]  = out_q[i];
        pad_oe[i] = dir_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  alt_o,
  input  logic [W-1:0]  alt_oe,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  pad_o,
  output logic [W-1:0]  pad_oe
);
  logic srst_n;
  logic [W-1:0] in_sync, out_q, dir_q, ode_q, alt_q;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  gpio_sync #(.W(W)) u_sync (.clk(clk), .rst_n(srst_n), .d(pad_i), .q(in_sync));

  gpio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(srst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .in_sync(in_sync), .rdata(bus_rdata),
    .out_q(out_q), .dir_q(dir_q), .ode_q(ode_q), .alt_q(alt_q)
  );

  gpio_padmux #(.W(W)) u_mux (
    .out_q(out_q), .dir_q(dir_q), .ode_q(ode_q), .alt_q(alt_q),
    .alt_o(alt_o), .alt_oe(alt_oe), .pad_o(pad_o), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpio_od_port_chk.sv
module gpio_od_port_chk #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          srst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pad_i,
  input logic [W-1:0]  alt_o,
  input logic [W-1:0]  alt_oe,
  input logic [W-1:0]  pad_o,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  in_sync,
  input logic [W-1:0]  out_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  ode_q,
  input logic [W-1:0]  alt_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  wr_out_store_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == AW'(0)) |=> (out_q == $past(bus_wdata)));

  // R4
  od_release_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((~alt_q & ode_q & out_q & pad_oe) == '0));

  // R4
  od_never_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((~alt_q & ode_q & pad_o) == '0));

  // R5
  alt_pass_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((alt_q & ((pad_o ^ alt_o) | (pad_oe ^ alt_oe))) == '0));

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q >= 2'd2) |-> (in_sync == $past(pad_i, 2)));

  // R7
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr >= AW'(4)) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(ode_q) && $stable(alt_q)));
endmodule

bind gpio_od_port gpio_od_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_i(pad_i), .alt_o(alt_o), .alt_oe(alt_oe),
  .pad_o(pad_o), .pad_oe(pad_oe), .in_sync(in_sync), .out_q(out_q),
  .dir_q(dir_q), .ode_q(ode_q), .alt_q(alt_q)
);

// File: tb/sim_gpio_od_port.sv
module sim_gpio_od_port;
  localparam int W = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] alt_o = '0;
  logic [W-1:0] alt_oe = '0;
  logic [W-1:0] pad_i = '0;
  logic [W-1:0] pad_o, pad_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_out = '0, m_dir = '0, m_ode = '0, m_alt = '0;

  always #2.5 clk = ~clk;

  gpio_od_port #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_o(alt_o), .alt_oe(alt_oe),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(idx); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (idx == 0) m_out = d;
    if (idx == 1) m_dir = d;
    if (idx == 2) m_ode = d;
    if (idx == 3) m_alt = d;
  endtask

  task automatic rd(input int idx, output logic [W-1:0] d);
    bus_addr = AW'(idx);
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [W-1:0] exp_o();
    return (m_alt & alt_o) | (~m_alt & ~m_ode & m_out);
  endfunction
  function automatic logic [W-1:0] exp_oe();
    return (m_alt & alt_oe) | (~m_alt & m_ode & ~m_out) | (~m_alt & ~m_ode & m_dir);
  endfunction

  task automatic check_pads(input string req);
    check({req, " pad_o"}, pad_o, exp_o());
    check({req, " pad_oe"}, pad_oe, exp_oe());
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(i, d);
      check("R1 reg", d, '0);
    end
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_o", pad_o, '0);
  endtask

  task automatic t_readback();
    logic [W-1:0] d;
    logic [W-1:0] pats [4] = '{32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h1234_5678};
    for (int i = 0; i < 4; i++) begin
      wr(i, pats[i]);
      rd(i, d);
      check("R2 readback", d, pats[i]);
    end
    wr(3, '0); wr(2, '0); wr(1, '0); wr(0, '0);
  endtask

  task automatic t_pushpull();
    wr(1, 32'hFFFF_0000);
    wr(0, 32'hF0F0_F0F0);
    check_pads("R3");
    wr(0, 32'h0000_FFFF);
    check_pads("R3");
  endtask

  task automatic t_opendrain();
    wr(1, 32'h0000_0000);
    wr(2, 32'hFFFF_FFFF);
    wr(0, 32'hAAAA_5555);
    check("R4 pad_o low", pad_o, '0);
    check("R4 pad_oe", pad_oe, 32'h5555_AAAA);
    wr(1, 32'hFFFF_FFFF);
    check("R4 dir ignored", pad_oe, 32'h5555_AAAA);
    wr(2, 32'h00FF_00FF);
    check_pads("R4 mixed");
  endtask

  task automatic t_alt();
    @(negedge clk);
    alt_o = 32'h1357_9BDF; alt_oe = 32'hFEDC_BA98;
    wr(3, 32'hFFFF_0000);
    check_pads("R5 split");
    wr(0, 32'h5A5A_5A5A); wr(1, 32'h0000_0000); wr(2, 32'h0F0F_0F0F);
    check("R5 ignored o", pad_o & 32'hFFFF_0000, alt_o & 32'hFFFF_0000);
    check("R5 ignored oe", pad_oe & 32'hFFFF_0000, alt_oe & 32'hFFFF_0000);
    check_pads("R5 rest");
  endtask

  task automatic t_sync();
    logic [W-1:0] d;
    @(negedge clk);
    pad_i = 32'hC0FF_EE11;
    @(negedge clk);
    rd(4, d);
    check("R6 one edge old", d, 32'h0000_0000);
    @(negedge clk);
    rd(4, d);
    check("R6 two edges", d, 32'hC0FF_EE11);
    wr(3, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    @(negedge clk);
    pad_i = 32'h0BAD_F00D;
    @(negedge clk); @(negedge clk);
    rd(4, d);
    check("R9 any mode", d, 32'h0BAD_F00D);
  endtask

  task automatic t_ignored();
    logic [W-1:0] d;
    logic [W-1:0] s_out, s_dir, s_ode, s_alt;
    s_out = m_out; s_dir = m_dir; s_ode = m_ode; s_alt = m_alt;
    for (int i = 4; i < 8; i++) begin
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(i); bus_wdata = 32'hFFFF_FFFF ^ s_out;
      @(negedge clk);
      bus_we = 1'b0;
    end
    rd(0, d); check("R7 out kept", d, s_out);
    rd(1, d); check("R7 dir kept", d, s_dir);
    rd(2, d); check("R7 ode kept", d, s_ode);
    rd(3, d); check("R7 alt kept", d, s_alt);
    for (int i = 5; i < 8; i++) begin
      rd(i, d); check("R7 unmapped read", d, '0);
    end
  endtask

  task automatic t_timing();
    wr(3, '0); wr(2, '0); wr(1, 32'hFFFF_FFFF); wr(0, '0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(0); bus_wdata = 32'h8000_0001;
    #1;
    check("R8 before edge", pad_o, '0);
    @(negedge clk);
    bus_we = 1'b0;
    check("R8 after edge", pad_o, 32'h8000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_readback();
    t_pushpull();
    t_opendrain();
    t_alt();
    t_sync();
    t_ignored();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule